// File: doc/BRIEF.md
# Non-Restoring Division Step Engine

This block provides one architected non-restoring division step and a small sequencer that applies it once per clock. Each step doubles the partial remainder and rotates one incoming bit into its low end. It then adds or subtracts the divisor, chosen by whether the remembered sign flag agrees with the divisor-sign flag. Three status flags carry state from one step to the next: Q holds the sign of the partial remainder, M holds the divisor sign and T holds the newest quotient bit. Software-visible division setup is reduced here to loading those three flags before the first step.

An operation enters through a valid/ready port carrying the high word (starting partial remainder), the low word of the dividend, the divisor and an optional flag load. The sequencer runs `W` steps. In each step the top bit of the low word is the bit rotated into the remainder, and the previous T is rotated into the bottom of the low word. The result leaves through a second valid/ready port. Back-pressure rules: `in_ready` is high only while the engine is idle, so the caller holds `in_valid` and its operands until the accepting edge. A finished result stays on the output port, unchanged, until the edge where `out_valid` and `out_ready` are both high. The engine accepts nothing new until that result has been taken.

For an unsigned division the flags start at zero. When the high word is below the divisor, the result word is then the exact quotient of the double-width dividend.

Top module: `nrdiv_engine`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: Operands are captured only on an edge where `in_valid` and `in_ready` are both high. `in_ready` is 0 from that edge until the result has been taken, and input values presented meanwhile have no effect on the result.
- R3: `out_valid` rises exactly `W` clock edges after the accepting edge.
- R4: Each step shifts the remainder left by one and puts the rotated-in bit at bit 0. It subtracts the divisor when the old Q equals M and adds it otherwise.
- R5: After each step, the new Q equals the remainder's bit `W-1` before the shift, XOR the carry-out (for an add) or borrow (for a subtract), XOR M.
- R6: After each step, T is 1 when the new Q equals M and 0 otherwise. `out_t` and `out_q` give T and Q after the last step.
- R7: The bit rotated into the remainder at each step is the top bit of the low word. The low word shifts left with the previous T in its bit 0. `out_quot` is the low word after one further such rotation with the final T.
- R8: With `in_flags_ext` = 0, Q, M and T start at 0 whatever `in_q`, `in_m` and `in_t` hold. With a high word below the divisor, `out_quot` then equals the unsigned quotient of {high word, low word} by the divisor.
- R9: With `in_flags_ext` = 1, Q, M and T start from `in_q`, `in_m` and `in_t`.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and every result output holds its value. After the edge where both are 1, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Engine idle and able to accept |
| in_rem_hi | input | W | Starting partial remainder (dividend high word) |
| in_dvd_lo | input | W | Dividend low word |
| in_divisor | input | W | Divisor |
| in_flags_ext | input | 1 | 1: load Q/M/T from the inputs; 0: load zeros |
| in_q | input | 1 | Initial Q when `in_flags_ext` = 1 |
| in_m | input | 1 | Initial M when `in_flags_ext` = 1 |
| in_t | input | 1 | Initial T when `in_flags_ext` = 1 |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_quot | output | W | Quotient word after the final rotation |
| out_rem | output | W | Partial remainder after the last step |
| out_q | output | 1 | Q after the last step |
| out_t | output | 1 | T after the last step |

## Verification
The bench builds the engine with the default `W` = 32, so each operation runs the full 32 steps. The bench compares results against an unsigned 64-by-32 quotient computed in plain arithmetic and against a step model written as a four-way case table. This width covers divisors of 1 and all ones, high words one below the divisor, and randomly loaded flag combinations in which every (old Q, M) pairing is seen many times. Random hold-off on `out_ready` and operand scrambling while the engine is busy exercise the back-pressure and capture rules.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_HOLD = 2'd2
  } seq_state_e;

  // sign flag, divisor-sign flag, rotated-in bit
  typedef struct packed {
    logic q;
    logic m;
    logic t;
  } div_flags_t;

endpackage

// File: rtl/nrdiv_step.sv
module nrdiv_step
  import nrdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] divisor_i,
  input  div_flags_t   flags_i,
  output logic [W-1:0] rem_o,
  output logic         q_o,
  output logic         t_o
);

  logic         do_sub;
  logic         msb_pre;
  logic [W-1:0] shifted;
  logic [W-1:0] operand;
  logic [W:0]   sum;
  logic         carry_or_borrow;

  always_comb begin
    do_sub   = (flags_i.q == flags_i.m);
    msb_pre  = rem_i[W-1];
    shifted  = {rem_i[W-2:0], flags_i.t};
    operand  = do_sub ? ~divisor_i : divisor_i;
    // one adder serves both directions: subtract is add of complement plus one
    sum      = {1'b0, shifted} + {1'b0, operand} + {{W{1'b0}}, do_sub};
    // add: carry out; subtract: borrow is the absence of carry out
    carry_or_borrow = do_sub ? ~sum[W] : sum[W];
    rem_o    = sum[W-1:0];
    q_o      = msb_pre ^ carry_or_borrow ^ flags_i.m;
    t_o      = (q_o == flags_i.m);
  end

endmodule

// File: rtl/nrdiv_seq_ctrl.sv
module nrdiv_seq_ctrl
  import nrdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic load_o,
  output logic step_o,
  output logic out_valid
);

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load_o  = 1'b0;
    step_o  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (in_valid) begin
          load_o  = 1'b1;
          cnt_d   = '0;
          state_d = SEQ_RUN;
        end
      end
      SEQ_RUN: begin
        step_o = 1'b1;
        cnt_d  = cnt_q + CW'(1);
        if (cnt_q == LAST) state_d = SEQ_HOLD;
      end
      SEQ_HOLD: begin
        if (out_ready) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign in_ready  = (state_q == SEQ_IDLE);
  assign out_valid = (state_q == SEQ_HOLD);

endmodule

// File: rtl/nrdiv_lo_shift.sv
module nrdiv_lo_shift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] lo_i,
  input  logic         step_i,
  input  logic         t_i,
  output logic         msb_o,
  output logic [W-1:0] quot_o
);

  logic [W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lo_q <= '0;
    else if (load_i) lo_q <= lo_i;
    else if (step_i) lo_q <= {lo_q[W-2:0], t_i};
  end

  assign msb_o  = lo_q[W-1];
  assign quot_o = {lo_q[W-2:0], t_i};

endmodule

// File: rtl/nrdiv_engine.sv
module nrdiv_engine
  import nrdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_rem_hi,
  input  logic [W-1:0] in_dvd_lo,
  input  logic [W-1:0] in_divisor,
  input  logic         in_flags_ext,
  input  logic         in_q,
  input  logic         in_m,
  input  logic         in_t,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_quot,
  output logic [W-1:0] out_rem,
  output logic         out_q,
  output logic         out_t
);

  logic         load, step;
  logic [W-1:0] rem_r, div_r, rem_nx;
  logic         q_r, m_r, t_r;
  logic         q_nx, t_nx;
  logic         lo_msb;
  div_flags_t   step_flags;
  div_flags_t   init_flags;

  nrdiv_seq_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .load_o    (load),
    .step_o    (step),
    .out_valid (out_valid)
  );

  nrdiv_lo_shift #(.W(W)) u_lo (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .lo_i   (in_dvd_lo),
    .step_i (step),
    .t_i    (t_r),
    .msb_o  (lo_msb),
    .quot_o (out_quot)
  );

  assign step_flags = '{q: q_r, m: m_r, t: lo_msb};

  nrdiv_step #(.W(W)) u_step (
    .rem_i     (rem_r),
    .divisor_i (div_r),
    .flags_i   (step_flags),
    .rem_o     (rem_nx),
    .q_o       (q_nx),
    .t_o       (t_nx)
  );

  assign init_flags = in_flags_ext ? '{q: in_q, m: in_m, t: in_t} : '{q: 1'b0, m: 1'b0, t: 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_r <= '0;
      div_r <= '0;
      q_r   <= 1'b0;
      m_r   <= 1'b0;
      t_r   <= 1'b0;
    end else if (load) begin
      rem_r <= in_rem_hi;
      div_r <= in_divisor;
      q_r   <= init_flags.q;
      m_r   <= init_flags.m;
      t_r   <= init_flags.t;
    end else if (step) begin
      rem_r <= rem_nx;
      q_r   <= q_nx;
      t_r   <= t_nx;
    end
  end

  assign out_rem = rem_r;
  assign out_q   = q_r;
  assign out_t   = t_r;

endmodule

// File: rtl/nrdiv_engine_chk.sv
module nrdiv_engine_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_quot,
  input logic [W-1:0] out_rem,
  input logic         out_q,
  input logic         out_t,
  input logic         m_r
);

  int unsigned since_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    since_acc <= 0;
    else if (in_valid && in_ready) since_acc <= 0;
    else if (!out_valid)           since_acc <= since_acc + 1;
  end

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (since_acc == W));

  // R6
  t_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_t == (out_q == m_r)));

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_quot) && $stable(out_rem)
                                   && $stable(out_q) && $stable(out_t)));

  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));

  // R2
  exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

endmodule

bind nrdiv_engine nrdiv_engine_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_quot  (out_quot),
  .out_rem   (out_rem),
  .out_q     (out_q),
  .out_t     (out_t),
  .m_r       (m_r)
);

// File: tb/nrdiv_engine_tb.sv
module nrdiv_engine_tb;

  localparam int W = 32;

  typedef struct {
    logic [W-1:0] quot;
    logic [W-1:0] rem;
    logic         q;
    logic         t;
    int           acc_cyc;
    logic         chk_div;
    logic [W-1:0] div_quot;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_rem_hi = '0, in_dvd_lo = '0, in_divisor = '0;
  logic         in_flags_ext = 1'b0, in_q = 1'b0, in_m = 1'b0, in_t = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_quot, out_rem;
  logic         out_q, out_t;

  int   checks = 0;
  int   fails  = 0;
  int   cyc    = 0;
  bit   drv_done = 1'b0;
  exp_t sb[$];

  nrdiv_engine #(.W(W)) u_dut (.*);

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // step model as a four-way case table on (old Q, M)
  task automatic ref_step(inout logic [W-1:0] r, input logic [W-1:0] d,
                          inout logic q, input logic m, inout logic t_in_out, input logic tin);
    logic [W-1:0] sh, res;
    logic qs, cb, nq;
    qs = r[W-1];
    sh = {r[W-2:0], tin};
    case ({q, m})
      2'b00: begin res = sh - d; cb = (sh < d);   nq = qs ? !cb : cb; end
      2'b01: begin res = sh + d; cb = (res < sh); nq = qs ? cb : !cb; end
      2'b10: begin res = sh + d; cb = (res < sh); nq = qs ? !cb : cb; end
      default: begin res = sh - d; cb = (sh < d); nq = qs ? cb : !cb; end
    endcase
    r = res;
    q = nq;
    t_in_out = (nq == m);
  endtask

  task automatic send(input logic [W-1:0] hi, input logic [W-1:0] lo, input logic [W-1:0] d,
                      input logic ext, input logic q0, input logic m0, input logic t0);
    exp_t e;
    logic [W-1:0] r, l;
    logic q, m, t, tin;
    r = hi; l = lo; d = d;
    q = ext ? q0 : 1'b0;
    m = ext ? m0 : 1'b0;
    t = ext ? t0 : 1'b0;
    for (int i = 0; i < W; i++) begin
      tin = l[W-1];
      l = {l[W-2:0], t};
      ref_step(r, d, q, m, t, tin);
    end
    e.quot = {l[W-2:0], t};
    e.rem  = r;
    e.q    = q;
    e.t    = t;
    e.chk_div  = !ext && (hi < d);
    e.div_quot = e.chk_div ? W'({hi, lo} / {{W{1'b0}}, d}) : '0;
    @(negedge clk);
    in_valid = 1'b1; in_rem_hi = hi; in_dvd_lo = lo; in_divisor = d;
    in_flags_ext = ext; in_q = q0; in_m = m0; in_t = t0;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    e.acc_cyc = cyc;
    sb.push_back(e);
    // R2: scramble inputs while busy; they must not reach the result
    in_valid = 1'b0;
    in_rem_hi = $urandom; in_dvd_lo = $urandom; in_divisor = $urandom;
    in_flags_ext = $urandom; in_q = $urandom; in_m = $urandom; in_t = $urandom;
    // R2: engine is busy after acceptance
    chk(!in_ready, "R2 in_ready low after accept", 64'(in_ready), 64'd0);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (out_valid) begin
        exp_t e;
        logic [W-1:0] cq, cr;
        logic cqf, ctf;
        int hold;
        cq = out_quot; cr = out_rem; cqf = out_q; ctf = out_t;
        if (sb.size() == 0) begin
          chk(1'b0, "R2 unexpected result", 64'(cq), 64'd0);
        end else begin
          e = sb.pop_front();
          chk(cyc - e.acc_cyc == W, "R3 latency", 64'(cyc - e.acc_cyc), 64'(W));
          chk(cq == e.quot, "R7 quotient word", 64'(cq), 64'(e.quot));
          chk(cr == e.rem, "R4 remainder", 64'(cr), 64'(e.rem));
          chk(cqf == e.q, "R5 final Q", 64'(cqf), 64'(e.q));
          chk(ctf == e.t, "R6 final T", 64'(ctf), 64'(e.t));
          if (e.chk_div)
            chk(cq == e.div_quot, "R8 unsigned quotient", 64'(cq), 64'(e.div_quot));
        end
        hold = $urandom_range(0, 3);
        for (int k = 0; k < hold; k++) begin
          @(negedge clk);
          chk(out_valid && out_quot == cq && out_rem == cr && out_q == cqf && out_t == ctf,
              "R10 held result", {31'd0, out_valid, out_quot}, {31'd1, cq});
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(!out_valid && in_ready, "R10 release", {62'd0, out_valid, in_ready}, 64'd1);
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'(cyc), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] d, hi;
    repeat (3) @(negedge clk);
    // R1
    chk(in_ready == 1'b1, "R1 in_ready after reset", 64'(in_ready), 64'd1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid, "R1 idle after release", {62'd0, in_ready, out_valid}, 64'd2);

    // R8 directed unsigned cases, flag inputs set to ones that must be ignored
    send(32'd0, 32'd100, 32'd7, 1'b0, 1'b1, 1'b1, 1'b1);
    send(32'd0, 32'hDEAD_BEEF, 32'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    send(32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b1);
    send(32'h0000_0006, 32'h0000_0000, 32'h0000_0007, 1'b0, 1'b0, 1'b1, 1'b0);
    send(32'd0, 32'd0, 32'h8000_0000, 1'b0, 1'b1, 1'b1, 1'b0);

    // R9 R5 directed loaded flag combinations
    for (int f = 0; f < 8; f++)
      send(32'h1234_5678, 32'h9ABC_DEF0, 32'h8765_4321, 1'b1, f[2], f[1], f[0]);

    // random unsigned divisions with quotient fitting in W bits
    for (int n = 0; n < 150; n++) begin
      d = $urandom;
      if (d == 0) d = 1;
      hi = $urandom % d;
      send(hi, $urandom, d, 1'b0, $urandom, $urandom, $urandom);
    end

    // R9 random loaded flags and unconstrained operands
    for (int n = 0; n < 100; n++)
      send($urandom, $urandom, $urandom, 1'b1, $urandom, $urandom, $urandom);

    while (sb.size() != 0 || out_valid) @(negedge clk);
    repeat (4) @(negedge clk);
    drv_done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule